// File: doc/BRIEF.md
# Sticky Error Status Register Pair with Warm-Reset-Proof Shadow

This block records error events for one error group in two parallel 32-bit sticky flag registers. Each bit of the event input sets the matching bit in both the primary status register and its shadow copy. A bit stays set until privileged software clears it with a write-one-to-clear access. Each register has its own address, and a clear sent to one of them never touches the other.

The two copies handle reset differently. A power-on reset clears both of them. A system (warm) reset clears only the primary register. Software can therefore still read after a warm restart which errors were pending before it. Reads are combinational, allowed at any privilege level, and select one of the two registers by address.

Top module: `err_shadow_status`

## Requirements
- R1: While power-on reset is asserted (por_n low), and in the first cycle after it is released, both registers read 0.
- R2: If bit i of err_evt is 1 at a rising clock edge, bit i of both the primary register (address STAT_ADDR, default 0x18) and the shadow register (address SHADOW_ADDR, default 0x3C) reads 1 from that edge on. The bit stays 1 after the event is removed.
- R3: A privileged write (reg_wr_en=1, reg_priv=1) to STAT_ADDR clears every primary bit whose reg_wdata bit is 1. Primary bits whose data bit is 0 are unchanged, and the shadow register is unchanged.
- R4: A privileged write to SHADOW_ADDR clears every shadow bit whose reg_wdata bit is 1. Shadow bits whose data bit is 0 are unchanged, and the primary register is unchanged.
- R5: A write with reg_priv=0 changes neither register, at either address.
- R6: If an event and a privileged clear hit the same bit of a register at the same edge, the bit reads 1 afterwards.
- R7: A clock edge with sys_rst_n low clears the primary register and leaves the shadow register unchanged.
- R8: A clock edge with por_n low clears both registers, whatever sys_rst_n and the other inputs are.
- R9: reg_rdata shows the register selected by reg_addr in the same cycle, whatever reg_priv is. Any other address reads 0.
- R10: A privileged write to any address other than the two register addresses changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears both registers |
| sys_rst_n | input | 1 | System reset, active low, synchronous; clears the primary register only |
| reg_addr | input | ADDR_W (8) | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (32) | Write data; a 1 bit requests a clear |
| reg_priv | input | 1 | 1 = privileged access |
| reg_rdata | output | DATA_W (32) | Read data for the register at reg_addr, 0 for any other address |
| err_evt | input | DATA_W (32) | Per-bit error event pulses |

## Verification
A flag that is wrongly set or lost shows on reg_rdata in the first cycle its address is selected after the edge that corrupted it. The reference model is compared at both addresses across all traffic, so such a fault is seen within a few cycles. Cross-coupling between the two copies is covered by clearing one copy and reading the other straight afterwards. The warm-reset fault classes (shadow cleared, or primary kept) appear at the first read after sys_rst_n is released. A set-versus-clear priority error appears in the cycle right after the colliding edge.

// File: rtl/esh_pkg.sv
package esh_pkg;
   // Largest data width the register bus of this group supports.
   localparam int unsigned MAX_DATA_W = 32;

   // Result of decoding a register access.
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STAT   = 2'd1,
      SEL_SHADOW = 2'd2
   } reg_sel_e;

   // True when a byte address sits on a word boundary for the given width.
   function automatic bit word_aligned(input int unsigned addr, input int unsigned data_w);
      return (addr % (data_w / 8)) == 0;
   endfunction
endpackage

// File: rtl/esh_flag_bank.sv
// A bank of sticky flags with a per-bit clear mask; a set beats a clear.
module esh_flag_bank #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             clr_en_i,
   input  logic [WIDTH-1:0] clr_mask_i,
   output logic [WIDTH-1:0] flags_o
);
   logic [WIDTH-1:0] clr_vec;

   assign clr_vec = clr_en_i ? clr_mask_i : '0;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (set_i[b]) begin
            flag_q <= 1'b1;
         end else if (clr_vec[b]) begin
            flag_q <= 1'b0;
         end
      end
      assign flags_o[b] = flag_q;
   end
endmodule

// File: rtl/esh_bus_decode.sv
// Address decode, privilege gating of clears and combinational read mux.
module esh_bus_decode
   import esh_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned STAT_ADDR   = 'h18,
   parameter int unsigned SHADOW_ADDR = 'h3C
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic              priv_i,
   input  logic [DATA_W-1:0] stat_flags_i,
   input  logic [DATA_W-1:0] shad_flags_i,
   output logic              stat_clr_o,
   output logic              shad_clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] SHAD_A = ADDR_W'(SHADOW_ADDR);

   reg_sel_e sel;
   logic     wr_ok;

   always_comb begin
      if (addr_i == STAT_A) begin
         sel = SEL_STAT;
      end else if (addr_i == SHAD_A) begin
         sel = SEL_SHADOW;
      end else begin
         sel = SEL_NONE;
      end
   end

   assign wr_ok      = wr_en_i && priv_i;
   assign stat_clr_o = wr_ok && (sel == SEL_STAT);
   assign shad_clr_o = wr_ok && (sel == SEL_SHADOW);

   always_comb begin
      unique case (sel)
         SEL_STAT:   rdata_o = stat_flags_i;
         SEL_SHADOW: rdata_o = shad_flags_i;
         default:    rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/err_shadow_status.sv
// Primary error status plus a shadow copy that survives system reset.
module err_shadow_status
   import esh_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned STAT_ADDR   = 'h18,
   parameter int unsigned SHADOW_ADDR = 'h3C
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_priv,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] err_evt
);
   localparam longint unsigned ADDR_SPAN = 64'd1 << ADDR_W;

   // Elaboration-time parameter checks.
   if (DATA_W < 8 || DATA_W > MAX_DATA_W || (DATA_W % 8) != 0) begin : g_bad_width
      $error("err_shadow_status: DATA_W must be a multiple of 8 between 8 and %0d", MAX_DATA_W);
   end
   if (STAT_ADDR == SHADOW_ADDR) begin : g_bad_overlap
      $error("err_shadow_status: the two register addresses must differ");
   end
   if (longint'(STAT_ADDR) >= ADDR_SPAN || longint'(SHADOW_ADDR) >= ADDR_SPAN) begin : g_bad_range
      $error("err_shadow_status: a register address does not fit in ADDR_W bits");
   end
   if (!word_aligned(STAT_ADDR, DATA_W) || !word_aligned(SHADOW_ADDR, DATA_W)) begin : g_bad_align
      $error("err_shadow_status: register addresses must be word aligned");
   end

   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] shad_q;
   logic              stat_clr;
   logic              shad_clr;
   logic              stat_rst_n;

   // Primary copy is reset by either source; shadow by power-on only.
   assign stat_rst_n = por_n && sys_rst_n;

   esh_bus_decode #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .STAT_ADDR   (STAT_ADDR),
      .SHADOW_ADDR (SHADOW_ADDR)
   ) u_dec (
      .addr_i       (reg_addr),
      .wr_en_i      (reg_wr_en),
      .priv_i       (reg_priv),
      .stat_flags_i (stat_q),
      .shad_flags_i (shad_q),
      .stat_clr_o   (stat_clr),
      .shad_clr_o   (shad_clr),
      .rdata_o      (reg_rdata)
   );

   esh_flag_bank #(.WIDTH(DATA_W)) u_stat (
      .clk        (clk),
      .rst_n      (stat_rst_n),
      .set_i      (err_evt),
      .clr_en_i   (stat_clr),
      .clr_mask_i (reg_wdata),
      .flags_o    (stat_q)
   );

   esh_flag_bank #(.WIDTH(DATA_W)) u_shad (
      .clk        (clk),
      .rst_n      (por_n),
      .set_i      (err_evt),
      .clr_en_i   (shad_clr),
      .clr_mask_i (reg_wdata),
      .flags_o    (shad_q)
   );
endmodule

// File: rtl/esh_checker.sv
module esh_checker #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned STAT_ADDR   = 'h18,
   parameter int unsigned SHADOW_ADDR = 'h3C
) (
   input logic              clk,
   input logic              por_n,
   input logic              sys_rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr_en,
   input logic              reg_priv,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [DATA_W-1:0] err_evt,
   input logic [DATA_W-1:0] stat_q,
   input logic [DATA_W-1:0] shad_q
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] SHAD_A = ADDR_W'(SHADOW_ADDR);

   // R2 and R6: an event bit is held in the primary copy after the edge.
   p_stat_set_r2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (err_evt != '0) |=> ((stat_q & $past(err_evt)) == $past(err_evt)));

   // R2 and R6: an event bit is held in the shadow copy after the edge.
   p_shad_set_r6: assert property (@(posedge clk) disable iff (!por_n)
      (err_evt != '0) |=> ((shad_q & $past(err_evt)) == $past(err_evt)));

   // R4 and R7: a shadow bit only falls after a privileged shadow write.
   p_shad_clear_only_r4: assert property (@(posedge clk) disable iff (!por_n)
      (($past(shad_q) & ~shad_q) != '0) |->
         $past(reg_wr_en && reg_priv && reg_addr == SHAD_A));

   // R3: a primary bit only falls after a privileged primary write or a system reset.
   p_stat_clear_only_r3: assert property (@(posedge clk) disable iff (!por_n)
      (($past(stat_q) & ~stat_q) != '0) |->
         ($past(reg_wr_en && reg_priv && reg_addr == STAT_A) || $past(!sys_rst_n)));

   // R5: an unprivileged write leaves the shadow copy with no fallen bit.
   p_unpriv_keep_r5: assert property (@(posedge clk) disable iff (!por_n)
      (reg_wr_en && !reg_priv) |=> (($past(shad_q) & ~shad_q) == '0));

   // R7: system reset empties the primary copy.
   p_sysrst_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
      !sys_rst_n |=> (stat_q == '0));

   // R9: an unmapped address reads zero.
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
      (reg_addr != STAT_A && reg_addr != SHAD_A) |-> (reg_rdata == '0));

   // R9: the shadow address reads the shadow copy.
   p_shadow_read_r9: assert property (@(posedge clk) disable iff (!por_n)
      (reg_addr == SHAD_A) |-> (reg_rdata == shad_q));
endmodule

bind err_shadow_status esh_checker #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .STAT_ADDR   (STAT_ADDR),
   .SHADOW_ADDR (SHADOW_ADDR)
) u_esh_chk (
   .clk       (clk),
   .por_n     (por_n),
   .sys_rst_n (sys_rst_n),
   .reg_addr  (reg_addr),
   .reg_wr_en (reg_wr_en),
   .reg_priv  (reg_priv),
   .reg_rdata (reg_rdata),
   .err_evt   (err_evt),
   .stat_q    (stat_q),
   .shad_q    (shad_q)
);

// File: tb/err_shadow_status_tb.sv
module err_shadow_status_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam logic [AW-1:0] A_STAT = 8'h18;
   localparam logic [AW-1:0] A_SHAD = 8'h3C;
   localparam logic [AW-1:0] A_NONE = 8'h20;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          sys_rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr_en = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic          reg_priv = 1'b0;
   logic [DW-1:0] reg_rdata;
   logic [DW-1:0] err_evt = '0;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // Behavioural reference state.
   logic [DW-1:0] m_stat = '0;
   logic [DW-1:0] m_shad = '0;

   err_shadow_status dut_i (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .reg_addr  (reg_addr),
      .reg_wr_en (reg_wr_en),
      .reg_wdata (reg_wdata),
      .reg_priv  (reg_priv),
      .reg_rdata (reg_rdata),
      .err_evt   (err_evt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Reference model, written from the requirements.
   always @(posedge clk) begin
      logic [DW-1:0] clr_s, clr_h;
      clr_s = (reg_wr_en && reg_priv && reg_addr == A_STAT) ? reg_wdata : '0;
      clr_h = (reg_wr_en && reg_priv && reg_addr == A_SHAD) ? reg_wdata : '0;
      if (!por_n) begin
         m_stat = '0;
         m_shad = '0;
      end else begin
         m_shad = (m_shad & ~clr_h) | err_evt;
         if (!sys_rst_n) m_stat = '0;
         else            m_stat = (m_stat & ~clr_s) | err_evt;
      end
   end

   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      if (a == A_STAT) return m_stat;
      if (a == A_SHAD) return m_shad;
      return '0;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: addr=%h actual=%h expected=%h", req, reg_addr, act, exp);
      end
   endtask

   // One bus cycle: drive at the falling edge, compare, then wait for the rising edge.
   task automatic cyc(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] wd,
                      input logic pv, input logic [DW-1:0] ev);
      @(negedge clk);
      reg_addr = a; reg_wr_en = we; reg_wdata = wd; reg_priv = pv; err_evt = ev;
      #1;
      check(cur_req, reg_rdata, model_read(a));
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic pv);
      cyc(a, 1'b0, '0, pv, '0);
   endtask

   // Read with a fixed expected value taken from the requirement.
   task automatic rd_exp(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      rd(a, 1'b0);
      check(req, reg_rdata, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      // R8: power-on reset with events and system reset active.
      cur_req = "R8";
      cyc(A_STAT, 1'b0, '0, 1'b1, 32'hFFFF_FFFF);
      rd_exp("R8", A_SHAD, 32'h0);
      @(negedge clk); por_n = 1'b1; sys_rst_n = 1'b1;
      // R1: both empty after release.
      cur_req = "R1";
      rd_exp("R1", A_STAT, 32'h0);
      rd_exp("R1", A_SHAD, 32'h0);

      // R2: set both copies; sticky after the pulse.
      cur_req = "R2";
      cyc(A_NONE, 1'b0, '0, 1'b0, 32'h8000_0001);
      rd_exp("R2", A_STAT, 32'h8000_0001);
      rd_exp("R2", A_SHAD, 32'h8000_0001);
      cyc(A_NONE, 1'b0, '0, 1'b0, 32'h0000_0100);
      rd_exp("R2", A_STAT, 32'h8000_0101);

      // R3: clear primary bit 0 only.
      cur_req = "R3";
      cyc(A_STAT, 1'b1, 32'h0000_0001, 1'b1, '0);
      rd_exp("R3", A_STAT, 32'h8000_0100);
      rd_exp("R3", A_SHAD, 32'h8000_0101);

      // R4: clear shadow bit 31 only.
      cur_req = "R4";
      cyc(A_SHAD, 1'b1, 32'h8000_0000, 1'b1, '0);
      rd_exp("R4", A_SHAD, 32'h0000_0101);
      rd_exp("R4", A_STAT, 32'h8000_0100);

      // R5: unprivileged clears at both addresses are ignored.
      cur_req = "R5";
      cyc(A_STAT, 1'b1, 32'hFFFF_FFFF, 1'b0, '0);
      cyc(A_SHAD, 1'b1, 32'hFFFF_FFFF, 1'b0, '0);
      rd_exp("R5", A_STAT, 32'h8000_0100);
      rd_exp("R5", A_SHAD, 32'h0000_0101);

      // R10: privileged write elsewhere is ignored.
      cur_req = "R10";
      cyc(A_NONE, 1'b1, 32'hFFFF_FFFF, 1'b1, '0);
      rd_exp("R10", A_STAT, 32'h8000_0100);
      rd_exp("R10", A_SHAD, 32'h0000_0101);

      // R6: set and clear of bit 4 at the same edge, both copies.
      cur_req = "R6";
      cyc(A_STAT, 1'b1, 32'h0000_0010, 1'b1, 32'h0000_0010);
      rd_exp("R6", A_STAT, 32'h8000_0110);
      cyc(A_SHAD, 1'b1, 32'h0000_0010, 1'b1, 32'h0000_0010);
      rd_exp("R6", A_SHAD, 32'h0000_0111);

      // R9: reads at user privilege and from an unmapped address.
      cur_req = "R9";
      rd(A_SHAD, 1'b0);
      check("R9", reg_rdata, 32'h0000_0111);
      rd(A_NONE, 1'b1);
      check("R9", reg_rdata, 32'h0);

      // R7: warm reset clears primary, keeps shadow.
      cur_req = "R7";
      @(negedge clk); sys_rst_n = 1'b0;
      cyc(A_STAT, 1'b0, '0, 1'b0, '0);
      @(negedge clk); sys_rst_n = 1'b1;
      rd_exp("R7", A_STAT, 32'h0);
      rd_exp("R7", A_SHAD, 32'h0000_0111);

      // R8: power-on reset empties the shadow too.
      cur_req = "R8";
      @(negedge clk); por_n = 1'b0;
      rd(A_SHAD, 1'b0);
      @(negedge clk); por_n = 1'b1;
      rd_exp("R8", A_SHAD, 32'h0);
      rd_exp("R8", A_STAT, 32'h0);

      // Mixed traffic compared against the model on every cycle.
      cur_req = "R2/R3/R4/R7 mixed";
      lf = 32'h1D2C_3B4A;
      for (int i = 0; i < 2000; i++) begin
         logic [AW-1:0] a;
         logic [31:0]   ev;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         case (lf[1:0])
            2'd0:    a = A_STAT;
            2'd1:    a = A_SHAD;
            2'd2:    a = A_NONE;
            default: a = lf[2] ? A_STAT : A_SHAD;
         endcase
         ev = (lf[7:3] == 5'd0) ? (32'h1 << lf[12:8]) : '0;
         @(negedge clk);
         sys_rst_n = (lf[20:15] != 6'd0);
         cyc(a, lf[13], {lf[15:0], lf[31:16]}, lf[14], ev);
      end
      @(negedge clk); sys_rst_n = 1'b1;
      rd(A_STAT, 1'b0);
      rd(A_SHAD, 1'b1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule